// File: doc/BRIEF.md
# Matrix Access Window with Wishbone Slave Port

This block is a Wishbone slave that fronts four internal storage arrays: a two-dimensional weight matrix, an input vector, a target vector and a bias vector. The arrays have no flat memory map. The host reaches each array through one fixed window address. Every access to a window stores or returns one element, and an internal walker then steps to the next element. The walk stays inside an index range that the host programs. The host sets start and stop indices for the row dimension (i) and the column dimension (j). A status register shows whether the block is ready and whether the walk has used up its range.

A host fills a matrix by setting the range and then writing the weight window the right number of times. It can poll the completion flag between writes. To read the contents back, it reads the same window in the same order. The block also holds a threshold word and a bias word. These are plain read/write registers for an attached compute engine, which is not part of this block.

Top module: `matrix_window_wb`

## Requirements
- R1: `ack` is high for exactly one cycle. It rises one clock after `stb` and `cyc` are sampled high while `ack` is low, and it is never high unless a request was present in the previous cycle.
- R2: After reset:
  - status reads 0x1, which means ready (bit 0) = 1, complete (bit 1) = 0 and interrupt enable (bit 3) = 0;
  - threshold and bias read 0;
  - start indices read 0;
  - the stop indices read MAX_I-1 and MAX_J-1;
  - all array elements read 0.
- R3: Threshold (0x01) and bias (0x02) read back the last 32-bit value written. Start-i (0x07), stop-i (0x08), start-j (0x09) and stop-j (0x0A) keep only the low log2(MAX_I) or log2(MAX_J) bits and read them back zero-extended.
- R4: A write to status (0x00) loads the interrupt-enable bit from data bit 3. Status bits 0 and 1 cannot be written.
- R5: Address 0x0E reads the ack latency, which is 1. Writes to it have no effect.
- R6: The weight window (0x13) visits (i,j) from (start_i,start_j) to (stop_i,stop_j), with j changing fastest. A write pass followed by a read pass over the same range returns the written values in the same order, and elements outside the range are left unchanged.
- R7: The input window (0x10) walks i from start_i to stop_i. The target window (0x11) and the bias-vector window (0x12) walk j from start_j to stop_j. Each element is a signed 32-bit word, for example bipolar +1 (0x00000001) or -1 (0xFFFFFFFF).
- R8: The complete bit reads 1 after the access that touched the last element of the range. It clears when a new traversal begins or when any start or stop register is written.
- R9: After completion, further accesses to the same window in the same direction are still acknowledged. They return 0, store nothing and do not move the walker.
- R10: A new traversal starts at (start_i,start_j) on the first access to a window that differs from the last window accessed, or on a change between read and write. The same applies after a start or stop register write.
- R11: Unmapped addresses read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| adr | input | AW | Register or window address |
| dat_i | input | DW | Write data |
| stb | input | 1 | Strobe |
| cyc | input | 1 | Bus cycle |
| we | input | 1 | 1 = write, 0 = read |
| ack | output | 1 | One-cycle transfer acknowledge |
| dat_o | output | DW | Read data, valid while ack is high |

## Verification
The hardest state to reach from the ports is a walker that has completed while the same window and direction are still active. Only there do accesses become ignored, and that can only be seen through later read-back passes. The stimulus completes short passes, including a single-element range, and then issues extra writes in the same direction. It reads back after a direction change and checks that the extra writes were not stored. Randomly placed sub-ranges are followed by a full-matrix read-back, which shows that nothing outside the programmed range was touched. A deliberate switch to another window partway through a pass shows that the walk restarts from the start corner.

// File: rtl/mwin_pkg.sv
package mwin_pkg;

   typedef enum logic [1:0] {
      WIN_WGT  = 2'd0,
      WIN_VIN  = 2'd1,
      WIN_TGT  = 2'd2,
      WIN_BVEC = 2'd3
   } win_e;

   localparam logic [4:0] A_STAT = 5'h00;
   localparam logic [4:0] A_THR  = 5'h01;
   localparam logic [4:0] A_BIAS = 5'h02;
   localparam logic [4:0] A_STI  = 5'h07;
   localparam logic [4:0] A_SPI  = 5'h08;
   localparam logic [4:0] A_STJ  = 5'h09;
   localparam logic [4:0] A_SPJ  = 5'h0A;
   localparam logic [4:0] A_LAT  = 5'h0E;
   localparam logic [4:0] A_VIN  = 5'h10;
   localparam logic [4:0] A_TGT  = 5'h11;
   localparam logic [4:0] A_BVEC = 5'h12;
   localparam logic [4:0] A_WGT  = 5'h13;

   localparam int ST_RDY   = 0;
   localparam int ST_DONE  = 1;
   localparam int ST_IRQEN = 3;

   localparam int ACK_LATENCY = 1;

endpackage

// File: rtl/mwin_wb_ack.sv
module mwin_wb_ack (
   input  logic clk,
   input  logic rst,
   input  logic stb,
   input  logic cyc,
   output logic accept,
   output logic ack
);
   // a request is taken once; the ack cycle itself never re-accepts
   assign accept = stb & cyc & ~ack;

   always_ff @(posedge clk) begin
      if (rst) ack <= 1'b0;
      else     ack <= accept;
   end
endmodule

// File: rtl/mwin_walker.sv
module mwin_walker
   import mwin_pkg::*;
#(
   parameter int IWI = 3,
   parameter int IWJ = 2
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           acc,
   input  win_e           win,
   input  logic           dir,
   input  logic           restart,
   input  logic [IWI-1:0] sti,
   input  logic [IWI-1:0] spi,
   input  logic [IWJ-1:0] stj,
   input  logic [IWJ-1:0] spj,
   output logic [IWI-1:0] cur_i,
   output logic [IWJ-1:0] cur_j,
   output logic           live,
   output logic           done
);
   logic           act_v;
   win_e           act_w;
   logic           act_d;
   logic [IWI-1:0] pi_q;
   logic [IWJ-1:0] pj_q;
   logic           fresh;
   logic           last_i;
   logic           last_j;

   assign fresh  = ~act_v | (win != act_w) | (dir != act_d);
   assign cur_i  = fresh ? sti : pi_q;
   assign cur_j  = fresh ? stj : pj_q;
   assign live   = fresh | ~done;
   assign last_i = (cur_i == spi);
   assign last_j = (cur_j == spj);

   always_ff @(posedge clk) begin
      if (rst) begin
         act_v <= 1'b0;
         act_w <= WIN_WGT;
         act_d <= 1'b0;
         pi_q  <= '0;
         pj_q  <= '0;
         done  <= 1'b0;
      end else if (restart) begin
         act_v <= 1'b0;
         done  <= 1'b0;
      end else if (acc && live) begin
         act_v <= 1'b1;
         act_w <= win;
         act_d <= dir;
         case (win)
            WIN_WGT: begin
               if (last_j) begin
                  pj_q <= stj;
                  pi_q <= cur_i + IWI'(1);
                  done <= last_i;
               end else begin
                  pj_q <= cur_j + IWJ'(1);
                  pi_q <= cur_i;
                  done <= 1'b0;
               end
            end
            WIN_VIN: begin
               pi_q <= cur_i + IWI'(1);
               pj_q <= cur_j;
               done <= last_i;
            end
            default: begin
               pj_q <= cur_j + IWJ'(1);
               pi_q <= cur_i;
               done <= last_j;
            end
         endcase
      end
   end
endmodule

// File: rtl/mwin_bank.sv
module mwin_bank #(
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   parameter bit CLEAR = 1'b1,
   localparam int AWD  = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           wen,
   input  logic [AWD-1:0] addr,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rdata
);
   logic [DW-1:0] mem [DEPTH];

   if (DEPTH < 2) begin : g_depth_bad
      $error("mwin_bank: DEPTH must be at least 2");
   end

   if (CLEAR) begin : g_clear
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
         end else if (wen) begin
            mem[addr] <= wdata;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (wen) mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/matrix_window_wb.sv
module matrix_window_wb
   import mwin_pkg::*;
#(
   parameter int AW          = 5,
   parameter int DW          = 32,
   parameter int MAX_I       = 8,
   parameter int MAX_J       = 4,
   parameter bit CLEAR_BANKS = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] adr,
   input  logic [DW-1:0] dat_i,
   input  logic          stb,
   input  logic          cyc,
   input  logic          we,
   output logic          ack,
   output logic [DW-1:0] dat_o
);
   localparam int IWI    = $clog2(MAX_I);
   localparam int IWJ    = $clog2(MAX_J);
   localparam int WDEPTH = MAX_I * MAX_J;

   if (AW < 5) begin : g_aw_bad
      $error("matrix_window_wb: AW must be at least 5");
   end
   if (DW < 8) begin : g_dw_bad
      $error("matrix_window_wb: DW must be at least 8");
   end
   if (MAX_I < 2 || (1 << IWI) != MAX_I) begin : g_mi_bad
      $error("matrix_window_wb: MAX_I must be a power of two >= 2");
   end
   if (MAX_J < 2 || (1 << IWJ) != MAX_J) begin : g_mj_bad
      $error("matrix_window_wb: MAX_J must be a power of two >= 2");
   end

   logic           accept;
   logic           is_win;
   win_e           win;
   logic           idx_wr;
   logic           wacc;
   logic           restart;
   logic [IWI-1:0] sti, spi, cur_i;
   logic [IWJ-1:0] stj, spj, cur_j;
   logic           live;
   logic           walk_done;
   logic           ready_q;
   logic           irq_en;
   logic [DW-1:0]  thr_q, bias_q;
   logic [DW-1:0]  rd_mux;
   logic [DW-1:0]  wgt_rd, vin_rd, tgt_rd, bvec_rd;
   logic           wgt_we, vin_we, tgt_we, bvec_we;
   logic           store;

   mwin_wb_ack u_ack (
      .clk    (clk),
      .rst    (rst),
      .stb    (stb),
      .cyc    (cyc),
      .accept (accept),
      .ack    (ack)
   );

   always_comb begin
      is_win = 1'b1;
      win    = WIN_WGT;
      if      (adr == AW'(A_WGT))  win = WIN_WGT;
      else if (adr == AW'(A_VIN))  win = WIN_VIN;
      else if (adr == AW'(A_TGT))  win = WIN_TGT;
      else if (adr == AW'(A_BVEC)) win = WIN_BVEC;
      else                         is_win = 1'b0;
   end

   assign idx_wr  = (adr == AW'(A_STI)) | (adr == AW'(A_SPI)) |
                    (adr == AW'(A_STJ)) | (adr == AW'(A_SPJ));
   assign wacc    = accept & is_win;
   assign restart = accept & we & idx_wr;

   mwin_walker #(
      .IWI (IWI),
      .IWJ (IWJ)
   ) u_walk (
      .clk     (clk),
      .rst     (rst),
      .acc     (wacc),
      .win     (win),
      .dir     (we),
      .restart (restart),
      .sti     (sti),
      .spi     (spi),
      .stj     (stj),
      .spj     (spj),
      .cur_i   (cur_i),
      .cur_j   (cur_j),
      .live    (live),
      .done    (walk_done)
   );

   assign store   = wacc & we & live;
   assign wgt_we  = store & (win == WIN_WGT);
   assign vin_we  = store & (win == WIN_VIN);
   assign tgt_we  = store & (win == WIN_TGT);
   assign bvec_we = store & (win == WIN_BVEC);

   mwin_bank #(.DW(DW), .DEPTH(WDEPTH), .CLEAR(CLEAR_BANKS)) u_wgt (
      .clk (clk), .rst (rst), .wen (wgt_we),
      .addr ({cur_i, cur_j}), .wdata (dat_i), .rdata (wgt_rd)
   );
   mwin_bank #(.DW(DW), .DEPTH(MAX_I), .CLEAR(CLEAR_BANKS)) u_vin (
      .clk (clk), .rst (rst), .wen (vin_we),
      .addr (cur_i), .wdata (dat_i), .rdata (vin_rd)
   );
   mwin_bank #(.DW(DW), .DEPTH(MAX_J), .CLEAR(CLEAR_BANKS)) u_tgt (
      .clk (clk), .rst (rst), .wen (tgt_we),
      .addr (cur_j), .wdata (dat_i), .rdata (tgt_rd)
   );
   mwin_bank #(.DW(DW), .DEPTH(MAX_J), .CLEAR(CLEAR_BANKS)) u_bvec (
      .clk (clk), .rst (rst), .wen (bvec_we),
      .addr (cur_j), .wdata (dat_i), .rdata (bvec_rd)
   );

   always_comb begin
      rd_mux = '0;
      if (adr == AW'(A_STAT)) begin
         rd_mux[ST_RDY]   = ready_q;
         rd_mux[ST_DONE]  = walk_done;
         rd_mux[ST_IRQEN] = irq_en;
      end
      else if (adr == AW'(A_THR))  rd_mux = thr_q;
      else if (adr == AW'(A_BIAS)) rd_mux = bias_q;
      else if (adr == AW'(A_STI))  rd_mux = DW'(sti);
      else if (adr == AW'(A_SPI))  rd_mux = DW'(spi);
      else if (adr == AW'(A_STJ))  rd_mux = DW'(stj);
      else if (adr == AW'(A_SPJ))  rd_mux = DW'(spj);
      else if (adr == AW'(A_LAT))  rd_mux = DW'(ACK_LATENCY);
      else if (is_win && live) begin
         case (win)
            WIN_WGT: rd_mux = wgt_rd;
            WIN_VIN: rd_mux = vin_rd;
            WIN_TGT: rd_mux = tgt_rd;
            default: rd_mux = bvec_rd;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ready_q <= 1'b0;
         irq_en  <= 1'b0;
         thr_q   <= '0;
         bias_q  <= '0;
         sti     <= '0;
         spi     <= IWI'(MAX_I - 1);
         stj     <= '0;
         spj     <= IWJ'(MAX_J - 1);
         dat_o   <= '0;
      end else begin
         ready_q <= 1'b1;
         if (accept) begin
            dat_o <= we ? '0 : rd_mux;
            if (we) begin
               if      (adr == AW'(A_STAT)) irq_en <= dat_i[ST_IRQEN];
               else if (adr == AW'(A_THR))  thr_q  <= dat_i;
               else if (adr == AW'(A_BIAS)) bias_q <= dat_i;
               else if (adr == AW'(A_STI))  sti    <= dat_i[IWI-1:0];
               else if (adr == AW'(A_SPI))  spi    <= dat_i[IWI-1:0];
               else if (adr == AW'(A_STJ))  stj    <= dat_i[IWJ-1:0];
               else if (adr == AW'(A_SPJ))  spj    <= dat_i[IWJ-1:0];
            end
         end
      end
   end
endmodule

// File: rtl/mwin_chk.sv
module mwin_chk (
   input logic clk,
   input logic rst,
   input logic stb,
   input logic cyc,
   input logic ack,
   input logic accept,
   input logic done,
   input logic ready
);
   // R1
   ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      ack |=> !ack);

   // R1
   ack_req_chk: assert property (@(posedge clk) disable iff (rst)
      ack |-> $past(stb && cyc));

   // R2
   ready_up_chk: assert property (@(posedge clk) disable iff (rst)
      !ready |=> ready);

   // R2
   ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ready |=> ready);

   // R8
   done_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> $past(accept));

   // R8
   done_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(done) |-> $past(accept));
endmodule

bind matrix_window_wb mwin_chk u_mwin_chk (
   .clk    (clk),
   .rst    (rst),
   .stb    (stb),
   .cyc    (cyc),
   .ack    (ack),
   .accept (accept),
   .done   (walk_done),
   .ready  (ready_q)
);

// File: tb/matrix_window_wb_bench.sv
`timescale 1ns/1ps
module matrix_window_wb_bench;
   localparam logic [4:0] R_STAT = 5'h00, R_THR = 5'h01, R_BIAS = 5'h02;
   localparam logic [4:0] R_STI = 5'h07, R_SPI = 5'h08, R_STJ = 5'h09, R_SPJ = 5'h0A;
   localparam logic [4:0] R_LAT = 5'h0E, R_VIN = 5'h10, R_TGT = 5'h11;
   localparam logic [4:0] R_BVEC = 5'h12, R_WGT = 5'h13;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  adr = '0;
   logic [31:0] dat_i = '0;
   logic        stb = 1'b0, cyc = 1'b0, we = 1'b0;
   logic        ack;
   logic [31:0] dat_o;

   int   checks = 0;
   int   fails  = 0;
   logic irq_q  = 1'b0;

   logic [31:0] wm  [8][4];
   logic [31:0] vin [8];
   logic [31:0] tgt [4];
   logic [31:0] bv  [4];

   always #2 clk = ~clk;

   matrix_window_wb u_matrix_window_wb (
      .clk (clk), .rst (rst), .adr (adr), .dat_i (dat_i),
      .stb (stb), .cyc (cyc), .we (we), .ack (ack), .dat_o (dat_o)
   );

   function automatic logic [31:0] stat_exp(input logic dn);
      return {28'd0, irq_q, 1'b0, dn, 1'b1};
   endfunction

   function automatic logic [31:0] bipolar();
      return ($urandom % 2) ? 32'h0000_0001 : 32'hFFFF_FFFF;
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus(input logic [4:0] a, input logic w,
                      input logic [31:0] d, output logic [31:0] q);
      @(negedge clk);
      adr = a; we = w; dat_i = d; stb = 1'b1; cyc = 1'b1;
      @(negedge clk);
      chk(ack === 1'b1, "R1 ack rise", {31'd0, ack}, 32'd1);
      q = dat_o;
      @(negedge clk);
      chk(ack === 1'b0, "R1 ack width", {31'd0, ack}, 32'd0);
      stb = 1'b0; cyc = 1'b0; we = 1'b0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      logic [31:0] q;
      bus(a, 1'b1, d, q);
   endtask

   task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
      logic [31:0] q;
      bus(a, 1'b0, 32'd0, q);
      chk(q === exp, req, q, exp);
   endtask

   task automatic set_range(input int si, input int pi, input int sj, input int pj);
      wr(R_STI, si); wr(R_SPI, pi); wr(R_STJ, sj); wr(R_SPJ, pj);
   endtask

   // R6 R8: write pass over weights, status checked after each element
   task automatic wgt_write_pass(input int si, input int pi, input int sj, input int pj);
      set_range(si, pi, sj, pj);
      for (int i = si; i <= pi; i++) begin
         for (int j = sj; j <= pj; j++) begin
            logic [31:0] v;
            v = $urandom;
            wr(R_WGT, v);
            wm[i][j] = v;
            rd_chk(R_STAT, stat_exp(i == pi && j == pj), "R8 complete flag");
         end
      end
   endtask

   task automatic wgt_read_pass(input int si, input int pi, input int sj, input int pj);
      set_range(si, pi, sj, pj);
      for (int i = si; i <= pi; i++)
         for (int j = sj; j <= pj; j++)
            rd_chk(R_WGT, wm[i][j], "R6 weight order");
   endtask

   // R7: vector windows; a = window, lo..hi the walked index
   task automatic vec_pass(input logic [4:0] a, input int lo, input int hi, input bit wmode);
      for (int k = lo; k <= hi; k++) begin
         logic [31:0] v;
         logic [31:0] e;
         if (wmode) begin
            v = (a == R_BVEC) ? $urandom : bipolar();
            wr(a, v);
            if (a == R_VIN) vin[k] = v;
            else if (a == R_TGT) tgt[k] = v;
            else bv[k] = v;
         end else begin
            if (a == R_VIN) e = vin[k];
            else if (a == R_TGT) e = tgt[k];
            else e = bv[k];
            rd_chk(a, e, "R7 vector element");
         end
         rd_chk(R_STAT, stat_exp(k == hi), "R8 vector complete");
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic [31:0] q;
      void'($urandom(32'd7701));
      for (int i = 0; i < 8; i++) begin
         vin[i] = '0;
         for (int j = 0; j < 4; j++) wm[i][j] = '0;
      end
      for (int j = 0; j < 4; j++) begin tgt[j] = '0; bv[j] = '0; end

      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;

      // R2 reset state
      rd_chk(R_STAT, 32'h1, "R2 status");
      rd_chk(R_THR, 32'h0, "R2 threshold");
      rd_chk(R_BIAS, 32'h0, "R2 bias");
      rd_chk(R_STI, 32'h0, "R2 start_i");
      rd_chk(R_SPI, 32'h7, "R2 stop_i");
      rd_chk(R_SPJ, 32'h3, "R2 stop_j");
      rd_chk(R_WGT, 32'h0, "R2 array zero");

      // R3 registers
      v = $urandom; wr(R_THR, v); rd_chk(R_THR, v, "R3 threshold");
      wr(R_THR, 32'h25); rd_chk(R_THR, 32'h25, "R3 threshold");
      v = $urandom; wr(R_BIAS, v); rd_chk(R_BIAS, v, "R3 bias");
      wr(R_STI, 32'h0000_0005); rd_chk(R_STI, 32'h5, "R3 start_i");
      wr(R_SPJ, 32'hFFFF_FFF3); rd_chk(R_SPJ, 32'h3, "R3 stop_j truncation");

      // R4 interrupt enable
      wr(R_STAT, 32'hFFFF_FFFF); irq_q = 1'b1;
      rd_chk(R_STAT, 32'h9, "R4 status all ones");
      wr(R_STAT, 32'h0); irq_q = 1'b0;
      rd_chk(R_STAT, 32'h1, "R4 status clear");
      wr(R_STAT, 32'h8); irq_q = 1'b1;
      rd_chk(R_STAT, 32'h9, "R4 status enable");

      // R5 latency register
      rd_chk(R_LAT, 32'h1, "R5 latency");
      wr(R_LAT, 32'h55);
      rd_chk(R_LAT, 32'h1, "R5 latency write ignored");

      // R11 unmapped
      wr(5'h1F, 32'hDEAD_BEEF);
      rd_chk(5'h1F, 32'h0, "R11 unmapped 1F");
      rd_chk(5'h05, 32'h0, "R11 unmapped 05");

      // R6 6x3 pass, then R9 stale write ignored
      wgt_write_pass(0, 5, 0, 2);
      wr(R_WGT, 32'hBADB_AD00);
      rd_chk(R_STAT, stat_exp(1'b1), "R9 stays complete");
      wgt_read_pass(0, 5, 0, 2);
      rd_chk(R_WGT, 32'h0, "R9 read after completion");
      rd_chk(R_STAT, stat_exp(1'b1), "R9 complete held");
      wgt_read_pass(0, 7, 0, 3);

      // R6 random sub-ranges, full read-back shows outside untouched
      for (int n = 0; n < 5; n++) begin
         int si, pi, sj, pj;
         si = $urandom % 8; pi = si + ($urandom % (8 - si));
         sj = $urandom % 4; pj = sj + ($urandom % (4 - sj));
         wgt_write_pass(si, pi, sj, pj);
         wgt_read_pass(0, 7, 0, 3);
      end

      // R7 vector windows
      set_range(1, 3, 0, 3);
      vec_pass(R_VIN, 1, 3, 1'b1);
      vec_pass(R_TGT, 0, 3, 1'b1);
      set_range(0, 7, 0, 3);
      vec_pass(R_VIN, 0, 7, 1'b0);
      vec_pass(R_TGT, 0, 3, 1'b0);

      // R8 R9 single-element bias range
      set_range(0, 7, 2, 2);
      v = $urandom; wr(R_BVEC, v); bv[2] = v;
      rd_chk(R_STAT, stat_exp(1'b1), "R8 single element complete");
      wr(R_BVEC, 32'h1234_5678);
      rd_chk(R_STAT, stat_exp(1'b1), "R9 stale write complete");
      rd_chk(R_BVEC, v, "R9 stale write not stored");
      rd_chk(R_BVEC, 32'h0, "R9 stale read zero");
      rd_chk(R_VIN, vin[0], "R10 fresh window start");
      rd_chk(R_STAT, stat_exp(1'b0), "R8 cleared by new traversal");
      set_range(0, 7, 0, 3);
      vec_pass(R_BVEC, 0, 3, 1'b0);

      // R8 range write clears completion
      rd_chk(R_STAT, stat_exp(1'b1), "R8 complete before range write");
      wr(R_STI, 32'h0);
      rd_chk(R_STAT, stat_exp(1'b0), "R8 range write clears");

      // R10 mid-pass window switch restarts
      set_range(0, 1, 0, 3);
      v = $urandom; wr(R_WGT, v); wm[0][0] = v;
      v = $urandom; wr(R_WGT, v); wm[0][1] = v;
      rd_chk(R_VIN, vin[0], "R10 other window starts at start_i");
      v = $urandom; wr(R_WGT, v); wm[0][0] = v;
      rd_chk(R_STAT, stat_exp(1'b0), "R10 not complete");
      wgt_read_pass(0, 7, 0, 3);

      bus(R_STAT, 1'b0, 32'd0, q);
      chk(q[0] === 1'b1, "R2 ready stays", q, 32'h1);
      finish_run();
   end
endmodule